// File: doc/BRIEF.md
# Keyed Address-Sequence Command Detector

This block snoops the access stream that a host drives into a memory and looks for a fixed key. The key is six reads in a row. The first five reads must hit five fixed prefix addresses in order. The address of the sixth read then picks the command:

- one address asks the memory controller to copy the working array into its persistent backing store;
- another address asks for the reverse copy.

Each access arrives as a one-cycle strobe, sampled on the clock edge that stands for the end of a chip-enable-controlled cycle. The strobe comes with a write flag and a 15-bit address. The output-enable state of the access plays no part.

Any write breaks a partial key. So does any read at an address other than the expected next one. While the controller reports busy, the detector ignores accesses completely. A command appears as a one-clock pulse on one of two outputs, one clock edge after the sixth access. The detector does not perform the access itself and checks no timing.

Top module: `cmd_seq_detect`

## Requirements
- R1: After reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F in that order, a read at 0x0FC0 raises `store_o` for exactly one clock cycle. The pulse starts on the clock edge that samples that sixth read, and `recall_o` stays low.
- R2: After the same five reads, a read at 0x0C63 raises `recall_o` for exactly one clock cycle, with the same timing, and `store_o` stays low.
- R3: The prefix reads count only in their fixed order. Reading two prefix addresses swapped breaks the key, and no command follows the remaining reads.
- R4: A write (`acc_wr`=1) taken at any step returns the detector to idle. This holds even when the write hits the expected address, and no command is issued for that key.
- R5: A read at an address that is neither the expected next one nor the first prefix address returns the detector to idle, and no command is issued.
- R6: A read at 0x0E38 that breaks a partial key restarts it at once: that read counts as step one. This includes a read at 0x0E38 in the sixth position.
- R7: After a command the detector is idle. A further read at a final address issues nothing until a complete new prefix has been read.
- R8: While `busy` is 1, accesses neither advance nor break the key and raise no output. The key resumes where it stood once `busy` returns to 0.
- R9: A synchronous reset (`rst`=1) returns the detector to idle with both outputs low. Progress made before the reset is discarded.
- R10: Clock cycles with `acc_vld`=0 between key reads do not disturb progress. Back-to-back accesses on consecutive cycles are each counted.
- R11: `store_o` and `recall_o` are never high together, and neither stays high for two clock cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its rising edge samples the access strobe |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | One-cycle strobe for each completed chip-enable-controlled access |
| acc_wr | input | 1 | 1 = the access is a write, 0 = a read |
| acc_addr | input | 15 | Address of the access |
| busy | input | 1 | Controller busy; accesses are ignored while it is 1 |
| store_o | output | 1 | One-cycle pulse: copy the array to the backing store |
| recall_o | output | 1 | One-cycle pulse: reload the array from the backing store |

## Verification
The bench builds the detector with its default parameters: the five-address prefix, the two final addresses and a 15-bit address. That single build reaches every step index, including the last prefix step next to both final addresses. It also reaches a restart by the first prefix address both mid-key and in the sixth position. Gaps of idle cycles, busy windows and a reset all fall between key reads of the same build. This lets the same prefix show resumption, idle return and discard against one known key.

// File: rtl/sqd_pkg.sv
package sqd_pkg;

  // Command selected by the final read of a completed prefix.
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } sqd_cmd_e;

  // Store wins if both final keys were ever set equal.
  function automatic sqd_cmd_e sqd_pick(input logic at_end, input logic hit_st,
                                        input logic hit_rc);
    if (!at_end)     return CMD_NONE;
    else if (hit_st) return CMD_STORE;
    else if (hit_rc) return CMD_RECALL;
    else             return CMD_NONE;
  endfunction

endpackage

// File: rtl/sqd_key_cmp.sv
module sqd_key_cmp #(
  parameter int                ADDR_W = 15,
  parameter int                PRE_LEN = 5,
  parameter logic [ADDR_W-1:0] PRE_KEYS [PRE_LEN] = '{default: '0},
  parameter logic [ADDR_W-1:0] STORE_KEY  = '0,
  parameter logic [ADDR_W-1:0] RECALL_KEY = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [PRE_LEN-1:0] pre_eq,
  output logic               st_eq,
  output logic               rc_eq
);

  // One comparator per prefix key, all evaluated in parallel.
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_cmp
    assign pre_eq[g] = (addr == PRE_KEYS[g]);
  end

  assign st_eq = (addr == STORE_KEY);
  assign rc_eq = (addr == RECALL_KEY);

endmodule

// File: rtl/sqd_step_ctrl.sv
module sqd_step_ctrl
  import sqd_pkg::*;
#(
  parameter int PRE_LEN = 5,
  localparam int SW = $clog2(PRE_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               is_wr,
  input  logic [PRE_LEN-1:0] pre_eq,
  input  logic               st_eq,
  input  logic               rc_eq,
  output logic [SW-1:0]      step,
  output logic               ev_adv,
  output logic               ev_restart,
  output logic               ev_abort,
  output logic               ev_store,
  output logic               ev_recall
);

  localparam logic [SW-1:0] LAST = SW'(PRE_LEN);

  logic     rd;
  logic     at_end;
  logic     exp_hit;
  sqd_cmd_e cmd;

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < PRE_LEN; i++) begin
      if (step == SW'(i)) exp_hit = pre_eq[i];
    end
  end

  assign rd         = take && !is_wr;
  assign at_end     = (step == LAST);
  assign cmd        = sqd_pick(at_end, st_eq, rc_eq);
  assign ev_store   = rd && (cmd == CMD_STORE);
  assign ev_recall  = rd && (cmd == CMD_RECALL);
  assign ev_adv     = rd && exp_hit;
  assign ev_restart = rd && !exp_hit && (cmd == CMD_NONE) && pre_eq[0];
  assign ev_abort   = take && !ev_adv && !ev_store && !ev_recall;

  always_ff @(posedge clk) begin
    if (rst)             step <= '0;
    else if (ev_adv)     step <= step + 1'b1;
    else if (ev_restart) step <= SW'(1);
    else if (take)       step <= '0;
  end

endmodule

// File: rtl/sqd_cmd_out.sv
module sqd_cmd_out (
  input  logic clk,
  input  logic rst,
  input  logic ev_store,
  input  logic ev_recall,
  output logic store_o,
  output logic recall_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_o  <= 1'b0;
      recall_o <= 1'b0;
    end else begin
      store_o  <= ev_store;
      recall_o <= ev_recall;
    end
  end

endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect #(
  parameter int                ADDR_W  = 15,
  parameter int                PRE_LEN = 5,
  parameter logic [ADDR_W-1:0] PRE_KEYS [PRE_LEN] =
    '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F},
  parameter logic [ADDR_W-1:0] STORE_KEY  = 15'h0FC0,
  parameter logic [ADDR_W-1:0] RECALL_KEY = 15'h0C63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              busy,
  output logic              store_o,
  output logic              recall_o
);

  localparam int SW = $clog2(PRE_LEN + 1);

  // Named internal events, visible to the bound checker.
  logic               take;
  logic [PRE_LEN-1:0] pre_eq;
  logic               st_eq;
  logic               rc_eq;
  logic [SW-1:0]      step;
  logic               ev_adv;
  logic               ev_restart;
  logic               ev_abort;
  logic               ev_store;
  logic               ev_recall;

  assign take = acc_vld && !busy;

  sqd_key_cmp #(
    .ADDR_W    (ADDR_W),
    .PRE_LEN   (PRE_LEN),
    .PRE_KEYS  (PRE_KEYS),
    .STORE_KEY (STORE_KEY),
    .RECALL_KEY(RECALL_KEY)
  ) u_cmp (
    .addr  (acc_addr),
    .pre_eq(pre_eq),
    .st_eq (st_eq),
    .rc_eq (rc_eq)
  );

  sqd_step_ctrl #(
    .PRE_LEN(PRE_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .is_wr     (acc_wr),
    .pre_eq    (pre_eq),
    .st_eq     (st_eq),
    .rc_eq     (rc_eq),
    .step      (step),
    .ev_adv    (ev_adv),
    .ev_restart(ev_restart),
    .ev_abort  (ev_abort),
    .ev_store  (ev_store),
    .ev_recall (ev_recall)
  );

  sqd_cmd_out u_out (
    .clk      (clk),
    .rst      (rst),
    .ev_store (ev_store),
    .ev_recall(ev_recall),
    .store_o  (store_o),
    .recall_o (recall_o)
  );

endmodule

// File: rtl/sqd_chk.sv
module sqd_chk #(
  parameter int                ADDR_W = 15,
  parameter int                SW = 3,
  parameter int                LAST = 5,
  parameter logic [ADDR_W-1:0] STORE_KEY  = '0,
  parameter logic [ADDR_W-1:0] RECALL_KEY = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              busy,
  input logic [SW-1:0]     step,
  input logic              store_o,
  input logic              recall_o
);

  // R11
  excl_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !(store_o && recall_o));

  // R11
  store_single_chk: assert property (@(posedge clk) disable iff (rst)
    store_o |=> !store_o);

  // R11
  recall_single_chk: assert property (@(posedge clk) disable iff (rst)
    recall_o |=> !recall_o);

  // R1
  store_cause_chk: assert property (@(posedge clk) disable iff (rst)
    store_o |-> $past(acc_vld && !busy && !acc_wr && acc_addr == STORE_KEY &&
                      step == SW'(LAST)));

  // R2
  recall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    recall_o |-> $past(acc_vld && !busy && !acc_wr && acc_addr == RECALL_KEY &&
                       step == SW'(LAST)));

  // R4
  write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && !busy && acc_wr) |=> (step == '0 && !store_o && !recall_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(step) && !store_o && !recall_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> $stable(step));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (step == '0 && !store_o && !recall_o));

endmodule

bind cmd_seq_detect sqd_chk #(
  .ADDR_W    (ADDR_W),
  .SW        (SW),
  .LAST      (PRE_LEN),
  .STORE_KEY (STORE_KEY),
  .RECALL_KEY(RECALL_KEY)
) u_sqd_chk (
  .clk     (clk),
  .rst     (rst),
  .acc_vld (acc_vld),
  .acc_wr  (acc_wr),
  .acc_addr(acc_addr),
  .busy    (busy),
  .step    (step),
  .store_o (store_o),
  .recall_o(recall_o)
);

// File: tb/test_cmd_seq_detect.sv
module test_cmd_seq_detect;

  localparam int CLK_PERIOD = 10;
  localparam logic [14:0] K [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};
  localparam logic [14:0] ST = 15'h0FC0;
  localparam logic [14:0] RC = 15'h0C63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0;
  logic        acc_wr = 1'b0;
  logic [14:0] acc_addr = '0;
  logic        busy = 1'b0;
  logic        store_o;
  logic        recall_o;

  int  n_chk = 0;
  int  n_err = 0;
  int  n_st = 0;
  int  n_rc = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq_detect i_cmd_seq_detect (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .busy(busy), .store_o(store_o), .recall_o(recall_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one access for one cycle and counts
  // the pulses visible one edge later.
  task automatic acc(input bit wr, input logic [14:0] a, input bit bz = 1'b0);
    acc_vld = 1'b1; acc_wr = wr; acc_addr = a; busy = bz;
    @(negedge clk);
    if (store_o) n_st++;
    if (recall_o) n_rc++;
    check(!(store_o && recall_o), "R11", int'(store_o) + int'(recall_o), 1);
  endtask

  task automatic idle(input int n);
    acc_vld = 1'b0; acc_wr = 1'b0; busy = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (store_o) n_st++;
      if (recall_o) n_rc++;
    end
  endtask

  task automatic prefix(input int from, input int upto);
    for (int i = from; i < upto; i++) acc(1'b0, K[i]);
  endtask

  task automatic clr();
    n_st = 0; n_rc = 0;
  endtask

  task automatic do_reset();
    acc_vld = 1'b0; rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(store_o == 0 && recall_o == 0, "R9 reset outputs", int'(store_o) + int'(recall_o), 0);
  endtask

  task automatic t_store();
    clr();
    prefix(0, 5);
    check(n_st == 0 && n_rc == 0, "R1 no pulse on prefix", n_st + n_rc, 0);
    acc(1'b0, ST);
    check(n_st == 1 && n_rc == 0, "R1 store pulse", n_st * 10 + n_rc, 10);
    idle(1);
    check(store_o == 0, "R11 one-cycle store", int'(store_o), 0);
    check(n_st == 1, "R1 single store", n_st, 1);
  endtask

  task automatic t_recall_gaps();
    clr();
    for (int i = 0; i < 5; i++) begin
      acc(1'b0, K[i]);
      idle(i + 1);
    end
    acc(1'b0, RC);
    check(n_rc == 1 && n_st == 0, "R2 R10 recall with gaps", n_rc * 10 + n_st, 10);
    idle(1);
    check(recall_o == 0, "R11 one-cycle recall", int'(recall_o), 0);
  endtask

  task automatic t_order();
    clr();
    acc(1'b0, K[0]); acc(1'b0, K[2]); acc(1'b0, K[1]);
    prefix(3, 5); acc(1'b0, ST);
    idle(2);
    check(n_st == 0 && n_rc == 0, "R3 swapped order", n_st + n_rc, 0);
  endtask

  task automatic t_write();
    clr();
    prefix(0, 3); acc(1'b1, K[3]);
    prefix(3, 5); acc(1'b0, ST);
    idle(2);
    check(n_st == 0, "R4 write at expected addr", n_st, 0);
    clr();
    prefix(0, 5); acc(1'b1, 15'h1234); acc(1'b0, RC);
    idle(2);
    check(n_rc == 0, "R4 write before final", n_rc, 0);
    clr();
    prefix(0, 5); acc(1'b1, ST);
    idle(2);
    check(n_st == 0, "R4 write at final addr", n_st, 0);
  endtask

  task automatic t_wrong();
    clr();
    prefix(0, 4); acc(1'b0, 15'h0000);
    prefix(4, 5); acc(1'b0, ST);
    idle(2);
    check(n_st == 0, "R5 wrong address", n_st, 0);
    clr();
    prefix(0, 5); acc(1'b0, 15'h7FFF); acc(1'b0, RC);
    idle(2);
    check(n_rc == 0, "R5 wrong sixth address", n_rc, 0);
  endtask

  task automatic t_restart();
    clr();
    acc(1'b0, K[0]); acc(1'b0, K[1]); acc(1'b0, K[0]);
    prefix(1, 5); acc(1'b0, RC);
    check(n_rc == 1, "R6 restart mid-key", n_rc, 1);
    clr();
    prefix(0, 5); acc(1'b0, K[0]);
    prefix(1, 5); acc(1'b0, ST);
    check(n_st == 1, "R6 restart at sixth", n_st, 1);
    idle(1);
  endtask

  task automatic t_after_cmd();
    clr();
    prefix(0, 5); acc(1'b0, ST);
    acc(1'b0, ST); acc(1'b0, RC);
    idle(2);
    check(n_st == 1 && n_rc == 0, "R7 idle after command", n_st * 10 + n_rc, 10);
    clr();
    prefix(0, 5); acc(1'b0, RC);
    prefix(4, 5); acc(1'b0, RC);
    idle(2);
    check(n_rc == 1, "R7 partial prefix after command", n_rc, 1);
  endtask

  task automatic t_busy();
    clr();
    prefix(0, 2);
    acc(1'b1, K[2], 1'b1);
    acc(1'b0, 15'h5555, 1'b1);
    acc(1'b0, K[0], 1'b1);
    prefix(2, 5); acc(1'b0, ST);
    check(n_st == 1, "R8 busy accesses ignored", n_st, 1);
    clr();
    prefix(0, 5); acc(1'b0, RC, 1'b1);
    idle(1);
    check(n_rc == 0, "R8 final read while busy", n_rc, 0);
    acc(1'b0, RC);
    check(n_rc == 1, "R8 resumes after busy", n_rc, 1);
    idle(1);
  endtask

  task automatic t_midreset();
    clr();
    prefix(0, 3);
    do_reset();
    prefix(3, 5); acc(1'b0, ST);
    idle(2);
    check(n_st == 0, "R9 reset discards progress", n_st, 0);
    clr();
    prefix(0, 5); acc(1'b0, ST);
    check(n_st == 1, "R9 usable after reset", n_st, 1);
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_store();
    t_recall_gaps();
    t_order();
    t_write();
    t_wrong();
    t_restart();
    t_after_cmd();
    t_busy();
    t_midreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule